// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address by walking an in-memory translation tree. A request carries the virtual address, the kind of access (load, store or instruction fetch), whether the requester runs in supervisor mode, a context number and the base of the context table. The walker first reads one context slot. It then follows table descriptors through up to three levels of page tables until it reaches a page entry or a fault. All reads and writes go through a single 32-bit word memory port with a request/acknowledge handshake.

A page entry may sit at level 1 (16 MB page), level 2 (256 KB page) or level 3 (4 KB page). At the leaf, the walker checks the entry's 3-bit permission code against the access. It writes the entry back when its referenced or modified flags need setting. It reports the physical address, page size, granted rights and a fault word, and raises `done` for one cycle. When translation is switched off, the walker maps the address directly without touching memory. In boot mode, instruction fetches are redirected into a boot ROM window.

Top module: `ptw_walker`

## Requirements
- R1: The context slot is read at (req_ctp << 4) + (req_ctx << 2). The level-n table address is ({entry[31:2],2'b00} << 4) + 4*index, where the index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R2: Entry bits [1:0] give the type: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. The fault word holds the level (0 = context slot, 1 to 3) in bits [9:8] and the kind in bits [4:2]. An invalid entry gives kind 1. A reserved type, a page entry in the context slot, a descriptor at level 3, or mem_err on a read gives kind 4.
- R3: A page entry at level 1, 2 or 3 gives res_size 2, 1 or 0 (16 MB, 256 KB, 4 KB). res_pa = (entry[31:8] << 12) + VA[23:0], VA[17:0] or VA[11:0] respectively.
- R4: The permission code is entry[4:2]. Code 6 or 7 from user mode gives fault word 0x00C (privilege). An access lacking the right it needs gives 0x008 (protection). Loads need read, stores need write, fetches need execute. Rights {r,w,x} per code are: 0 r; 1 rw; 2 rx; 3 rwx; 4 x; 5 user r / supervisor rw; 6 supervisor rx; 7 supervisor rwx.
- R5: When cfg_nofault is set, a user-mode permission fault is suppressed. The walk then completes with fault word 0 and the code's user rights.
- R6: When a leaf passes its check and its referenced bit (bit 5) is clear, or a store finds the modified bit (bit 6) clear, the entry is written back to the same address with bit 5 set, and with bit 6 set for a store. Otherwise no write is made.
- R7: res_perm is {read, write, exec}. The write bit is cleared when the entry's modified bit, after any write-back, is clear.
- R8: With cfg_translate low, no memory access is made and done rises on the cycle after acceptance. If cfg_boot is set and the access is a fetch, res_pa = cfg_prom_base | VA[18:0] with rights r-x. In every other case res_pa = VA with rights rwx.
- R9: The walker has at most one memory operation in flight. mem_rd and mem_wr are never both high. Each is held with a stable address until mem_ack.
- R10: A request is accepted only while busy is low. done is a one-cycle pulse. The result outputs change only together with done and hold until the next done.
- R11: A walk that ends in a fault reports res_pa, res_size and res_perm as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_super | input | 1 | Supervisor-mode access |
| req_ctx | input | CTX_W | Context number |
| req_ctp | input | 32 | Context table base pointer |
| cfg_translate | input | 1 | Translation enabled |
| cfg_boot | input | 1 | Boot mode for untranslated fetches |
| cfg_nofault | input | 1 | Suppress user permission faults |
| cfg_prom_base | input | PA_W | Boot ROM base address |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | PA_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Operation complete |
| mem_err | input | 1 | Read error, valid with mem_ack |
| busy | output | 1 | Not accepting requests |
| done | output | 1 | Result valid pulse |
| res_pa | output | PA_W | Physical address |
| res_size | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| res_perm | output | 3 | Granted rights {r,w,x} |
| res_fault | output | 10 | Fault word, 0 when none |

## Verification
The assertions check the cycle-level rules on every cycle. These are the memory handshake (held request, stable address, no read/write overlap), the one-cycle done pulse, results that stay put between completions, the flags in every written-back entry, and zero results on faults. Only the bench scenarios show the rest, because those outcomes depend on table contents the assertions cannot see. That covers the correct path through the tree, the fault level and kind for each malformed entry, the rights decoding, the no-fault suppression, the write-back images left in memory, and the boot-mode mapping.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int WORD_W    = 32;
    localparam int REF_BIT   = 5;
    localparam int MOD_BIT   = 6;
    localparam int ACC_LSB   = 2;
    localparam int FRAME_LSB = 8;
    localparam int PAGE_SH   = 12;

    typedef enum logic [1:0] {K_LOAD = 2'd0, K_STORE = 2'd1, K_FETCH = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [1:0] {E_INVALID = 2'd0, E_TABLE = 2'd1, E_PAGE = 2'd2, E_RSVD = 2'd3} etype_e;
    typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_256K = 2'd1, SZ_16M = 2'd2} size_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ = 2'd1, ST_WRITE = 2'd2} state_e;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLATE   = 3'd4;
    localparam logic [9:0] CODE_PROT  = 10'h008;
    localparam logic [9:0] CODE_PRIV  = 10'h00C;

    function automatic logic [9:0] walk_fault(input logic [1:0] lvl, input logic [2:0] kind);
        return {lvl, 3'b000, kind, 2'b00};
    endfunction

    // rights as {read, write, exec}
    function automatic logic [2:0] rights_of(input logic [2:0] acc, input logic sup);
        case (acc)
            3'd0:    return 3'b100;
            3'd1:    return 3'b110;
            3'd2:    return 3'b101;
            3'd3:    return 3'b111;
            3'd4:    return 3'b001;
            3'd5:    return sup ? 3'b110 : 3'b100;
            3'd6:    return sup ? 3'b101 : 3'b000;
            default: return sup ? 3'b111 : 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  kind_e      kind,
    input  logic       sup,
    input  logic [2:0] acc,
    input  logic       nofault,
    output logic [9:0] code,
    output logic [2:0] rights,
    output logic       pass
);
    logic need_w, need_x, need_r;

    always_comb begin
        rights = rights_of(acc, sup);
        need_w = (kind == K_STORE);
        need_x = (kind == K_FETCH);
        need_r = !need_w && !need_x;
        if (!sup && acc[2] && acc[1]) begin
            code = CODE_PRIV;
        end else if ((need_r && !rights[2]) || (need_w && !rights[1]) || (need_x && !rights[0])) begin
            code = CODE_PROT;
        end else begin
            code = '0;
        end
        pass = (code == '0) || (nofault && !sup);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8,
    parameter int PA_W  = 36
) (
    input  logic [WORD_W-1:0] ctp,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [WORD_W-1:0] va,
    input  logic [1:0]        lvl,
    input  logic [WORD_W-1:0] entry,
    output logic [PA_W-1:0]   ctx_addr,
    output logic [PA_W-1:0]   tbl_addr,
    output logic [PA_W-1:0]   leaf_pa
);
    logic [PA_W-1:0] base;
    logic [7:0]      idx;
    logic [PA_W-1:0] frame;
    logic [23:0]     offs;

    always_comb begin
        ctx_addr = (PA_W'(ctp) << 4) + (PA_W'(ctx) << 2);
        base     = PA_W'({entry[WORD_W-1:2], 2'b00}) << 4;
        case (lvl)
            2'd0:    idx = va[31:24];
            2'd1:    idx = {2'b00, va[23:18]};
            2'd2:    idx = {2'b00, va[17:12]};
            default: idx = '0;
        endcase
        tbl_addr = base + (PA_W'(idx) << 2);
        frame    = PA_W'(entry[WORD_W-1:FRAME_LSB]) << PAGE_SH;
        case (lvl)
            2'd1:    offs = va[23:0];
            2'd2:    offs = {6'd0, va[17:0]};
            default: offs = {12'd0, va[11:0]};
        endcase
        leaf_pa = frame + PA_W'(offs);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W     = 8,
    parameter int PA_W      = 36,
    parameter int PROM_LOWW = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [31:0]       req_ctp,
    input  logic              cfg_translate,
    input  logic              cfg_boot,
    input  logic              cfg_nofault,
    input  logic [PA_W-1:0]   cfg_prom_base,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [PA_W-1:0]   mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              busy,
    output logic              done,
    output logic [PA_W-1:0]   res_pa,
    output logic [1:0]        res_size,
    output logic [2:0]        res_perm,
    output logic [9:0]        res_fault
);
    state_e            state;
    logic [1:0]        lvl;
    logic [PA_W-1:0]   addr_q;
    logic [31:0]       wdata_q;
    logic [31:0]       va_q;
    kind_e             kind_q;
    logic              sup_q, nf_q, done_q;
    logic [PA_W-1:0]   pend_pa;
    logic [1:0]        pend_size;
    logic [2:0]        pend_perm;
    logic [PA_W-1:0]   res_pa_q;
    logic [1:0]        res_size_q;
    logic [2:0]        res_perm_q;
    logic [9:0]        res_fault_q;

    logic [PA_W-1:0]   ctx_addr, tbl_addr, leaf_pa;
    logic [9:0]        pc_code;
    logic [2:0]        pc_rights;
    logic              pc_pass;

    logic              fin_valid, start_walk, go_desc, go_write;
    logic [PA_W-1:0]   fin_pa;
    logic [1:0]        fin_size;
    logic [2:0]        fin_perm;
    logic [9:0]        fin_fault;
    logic [31:0]       new_entry;
    logic              need_wb, is_store, boot_fetch;
    etype_e            etype;

    ptw_addr_gen #(.CTX_W(CTX_W), .PA_W(PA_W)) u_addr (
        .ctp(req_ctp), .ctx(req_ctx), .va(va_q), .lvl(lvl), .entry(mem_rdata),
        .ctx_addr(ctx_addr), .tbl_addr(tbl_addr), .leaf_pa(leaf_pa)
    );

    ptw_perm_check u_perm (
        .kind(kind_q), .sup(sup_q), .acc(mem_rdata[ACC_LSB+2:ACC_LSB]), .nofault(nf_q),
        .code(pc_code), .rights(pc_rights), .pass(pc_pass)
    );

    always_comb begin
        fin_valid  = 1'b0;
        start_walk = 1'b0;
        go_desc    = 1'b0;
        go_write   = 1'b0;
        fin_pa     = '0;
        fin_size   = '0;
        fin_perm   = '0;
        fin_fault  = '0;
        etype      = etype_e'(mem_rdata[1:0]);
        is_store   = (kind_q == K_STORE);
        need_wb    = !mem_rdata[REF_BIT] || (is_store && !mem_rdata[MOD_BIT]);
        new_entry  = mem_rdata | (32'd1 << REF_BIT) | (is_store ? (32'd1 << MOD_BIT) : 32'd0);
        boot_fetch = cfg_boot && (kind_e'(req_kind) == K_FETCH);
        unique case (state)
            ST_IDLE: begin
                if (req_valid && !done_q) begin
                    if (!cfg_translate) begin
                        fin_valid = 1'b1;
                        fin_pa    = boot_fetch
                                  ? (cfg_prom_base | PA_W'(req_va[PROM_LOWW-1:0]))
                                  : PA_W'(req_va);
                        fin_perm  = boot_fetch ? 3'b101 : 3'b111;
                        fin_size  = SZ_4K;
                    end else begin
                        start_walk = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        fin_valid = 1'b1;
                        fin_fault = walk_fault(lvl, FT_XLATE);
                    end else begin
                        unique case (etype)
                            E_INVALID: begin
                                fin_valid = 1'b1;
                                fin_fault = walk_fault(lvl, FT_INVALID);
                            end
                            E_RSVD: begin
                                fin_valid = 1'b1;
                                fin_fault = walk_fault(lvl, FT_XLATE);
                            end
                            E_TABLE: begin
                                if (lvl == 2'd3) begin
                                    fin_valid = 1'b1;
                                    fin_fault = walk_fault(lvl, FT_XLATE);
                                end else begin
                                    go_desc = 1'b1;
                                end
                            end
                            E_PAGE: begin
                                if (lvl == 2'd0) begin
                                    fin_valid = 1'b1;
                                    fin_fault = walk_fault(lvl, FT_XLATE);
                                end else if (!pc_pass) begin
                                    fin_valid = 1'b1;
                                    fin_fault = pc_code;
                                end else begin
                                    fin_pa   = leaf_pa;
                                    fin_size = (lvl == 2'd1) ? SZ_16M : (lvl == 2'd2) ? SZ_256K : SZ_4K;
                                    fin_perm = pc_rights & {1'b1, new_entry[MOD_BIT], 1'b1};
                                    if (need_wb) go_write = 1'b1;
                                    else         fin_valid = 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    fin_valid = 1'b1;
                    fin_pa    = pend_pa;
                    fin_size  = pend_size;
                    fin_perm  = pend_perm;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            lvl         <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            va_q        <= '0;
            kind_q      <= K_LOAD;
            sup_q       <= 1'b0;
            nf_q        <= 1'b0;
            done_q      <= 1'b0;
            pend_pa     <= '0;
            pend_size   <= '0;
            pend_perm   <= '0;
            res_pa_q    <= '0;
            res_size_q  <= '0;
            res_perm_q  <= '0;
            res_fault_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_walk) begin
                va_q   <= req_va;
                kind_q <= kind_e'(req_kind);
                sup_q  <= req_super;
                nf_q   <= cfg_nofault;
                lvl    <= 2'd0;
                addr_q <= ctx_addr;
                state  <= ST_READ;
            end
            if (go_desc) begin
                lvl    <= lvl + 2'd1;
                addr_q <= tbl_addr;
            end
            if (go_write) begin
                wdata_q   <= new_entry;
                pend_pa   <= fin_pa;
                pend_size <= fin_size;
                pend_perm <= fin_perm;
                state     <= ST_WRITE;
            end
            if (fin_valid) begin
                res_pa_q    <= fin_pa;
                res_size_q  <= fin_size;
                res_perm_q  <= fin_perm;
                res_fault_q <= fin_fault;
                done_q      <= 1'b1;
                state       <= ST_IDLE;
            end
        end
    end

    assign mem_rd    = (state == ST_READ);
    assign mem_wr    = (state == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign busy      = (state != ST_IDLE) || done_q;
    assign done      = done_q;
    assign res_pa    = res_pa_q;
    assign res_size  = res_size_q;
    assign res_perm  = res_perm_q;
    assign res_fault = res_fault_q;

    // R9: no read and write overlap
    p_rdwr_excl_r9: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
    // R9: read held with stable address until acknowledged
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));
    // R9: write held with stable address and data until acknowledged
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R10: results move only with done
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_pa) && $stable(res_perm) && $stable(res_size) && $stable(res_fault)));
    // R6: written-back entry is a page entry with referenced set
    p_wb_ref_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata[REF_BIT] && mem_wdata[1:0] == 2'd2));
    // R6: store write-back sets modified
    p_wb_mod_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && kind_q == K_STORE) |-> mem_wdata[MOD_BIT]);
    // R11: faulting result carries no mapping
    p_fault_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (done && res_fault != 10'd0) |-> (res_pa == '0 && res_perm == 3'd0 && res_size == 2'd0));

endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        sup;
        logic [7:0]  ctx;
        logic        nf;
        logic [9:0]  fault;
        logic [35:0] pa;
        logic [1:0]  size;
        logic [2:0]  perm;
        logic [2:0]  nrd;
    } vec_t;

    // va, kind(0 ld 1 st 2 fetch), sup, ctx, nofault, fault, pa, size, perm, reads
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h01123456, 2'd0, 1'b1, 8'd1, 1'b0, 10'h000, 36'h002123456, 2'd2, 3'b111, 3'd2},
        '{32'h01123456, 2'd2, 1'b0, 8'd1, 1'b0, 10'h000, 36'h002123456, 2'd2, 3'b111, 3'd2},
        '{32'h02012345, 2'd0, 1'b0, 8'd1, 1'b0, 10'h000, 36'h000312345, 2'd1, 3'b100, 3'd3},
        '{32'h03000000, 2'd0, 1'b0, 8'd1, 1'b0, 10'h104, 36'h0,         2'd0, 3'b000, 3'd2},
        '{32'h04000000, 2'd0, 1'b1, 8'd1, 1'b0, 10'h110, 36'h0,         2'd0, 3'b000, 3'd2},
        '{32'h02080000, 2'd0, 1'b1, 8'd1, 1'b0, 10'h204, 36'h0,         2'd0, 3'b000, 3'd3},
        '{32'h020C0000, 2'd0, 1'b1, 8'd1, 1'b0, 10'h210, 36'h0,         2'd0, 3'b000, 3'd3},
        '{32'h02046000, 2'd0, 1'b1, 8'd1, 1'b0, 10'h310, 36'h0,         2'd0, 3'b000, 3'd4},
        '{32'h02047000, 2'd0, 1'b1, 8'd1, 1'b0, 10'h304, 36'h0,         2'd0, 3'b000, 3'd4},
        '{32'h02048ABC, 2'd0, 1'b0, 8'd1, 1'b0, 10'h00C, 36'h0,         2'd0, 3'b000, 3'd4},
        '{32'h02048ABC, 2'd0, 1'b0, 8'd1, 1'b1, 10'h000, 36'h000780ABC, 2'd0, 3'b000, 3'd4},
        '{32'h02048ABC, 2'd2, 1'b1, 8'd1, 1'b0, 10'h000, 36'h000780ABC, 2'd0, 3'b101, 3'd4},
        '{32'h02049000, 2'd1, 1'b0, 8'd1, 1'b0, 10'h008, 36'h0,         2'd0, 3'b000, 3'd4},
        '{32'h02049000, 2'd1, 1'b0, 8'd1, 1'b1, 10'h000, 36'h000990000, 2'd0, 3'b100, 3'd4},
        '{32'h00000000, 2'd0, 1'b1, 8'd2, 1'b0, 10'h004, 36'h0,         2'd0, 3'b000, 3'd1},
        '{32'h00000000, 2'd0, 1'b1, 8'd3, 1'b0, 10'h010, 36'h0,         2'd0, 3'b000, 3'd1},
        '{32'h01000000, 2'd1, 1'b1, 8'd1, 1'b0, 10'h000, 36'h002000000, 2'd2, 3'b111, 3'd2},
        '{32'h02049000, 2'd0, 1'b1, 8'd1, 1'b0, 10'h000, 36'h000990000, 2'd0, 3'b100, 3'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic [7:0]  req_ctx = '0;
    logic [31:0] req_ctp = 32'h10;
    logic        cfg_translate = 1'b1;
    logic        cfg_boot = 1'b0;
    logic        cfg_nofault = 1'b0;
    logic [35:0] cfg_prom_base = 36'h0F0000000;
    logic        mem_rd, mem_wr;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        busy, done;
    logic [35:0] res_pa;
    logic [1:0]  res_size;
    logic [2:0]  res_perm;
    logic [9:0]  res_fault;

    logic [31:0] mem [4096];
    logic [35:0] err_addr = '1;
    int          n_rd = 0;
    int          n_wr = 0;
    int          total = 0;
    int          bad = 0;
    int          lat = 0;

    always #5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind),
        .req_super(req_super), .req_ctx(req_ctx), .req_ctp(req_ctp),
        .cfg_translate(cfg_translate), .cfg_boot(cfg_boot), .cfg_nofault(cfg_nofault),
        .cfg_prom_base(cfg_prom_base), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .busy(busy), .done(done), .res_pa(res_pa), .res_size(res_size), .res_perm(res_perm),
        .res_fault(res_fault)
    );

    // word memory: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if ((mem_rd || mem_wr) && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_rd) begin
                mem_rdata <= mem[mem_addr[13:2]];
                mem_err   <= (mem_addr == err_addr);
                n_rd      <= n_rd + 1;
            end else begin
                mem[mem_addr[13:2]] <= mem_wdata;
                mem_err   <= 1'b0;
                n_wr      <= n_wr + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic sup,
                        input logic [7:0] ctx, input logic nf);
        int cnt = 0;
        while (busy) @(negedge clk);
        req_va = va; req_kind = kind; req_super = sup; req_ctx = ctx; cfg_nofault = nf;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        lat = cnt;
        if (!done) chk("R10 walk timeout", 64'd0, 64'd1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[12'h041] = 32'h00000041;  // 0x104 ctx 1 -> L1 at 0x400
        mem[12'h043] = 32'h00000002;  // 0x10C ctx 3 -> page entry in context slot
        mem[12'h101] = 32'h0020006E;  // 0x404 16MB, acc3, R M
        mem[12'h102] = 32'h00000081;  // 0x408 -> L2 at 0x800
        mem[12'h104] = 32'h00000003;  // 0x410 reserved
        mem[12'h200] = 32'h00030026;  // 0x800 256KB acc1 R
        mem[12'h201] = 32'h000000A1;  // 0x804 -> L3 at 0xA00
        mem[12'h203] = 32'h00000003;  // 0x80C reserved
        mem[12'h285] = 32'h00045616;  // 0xA14 acc5 no R/M
        mem[12'h286] = 32'h00000001;  // 0xA18 descriptor at L3
        mem[12'h288] = 32'h0007803A;  // 0xA20 acc6 R
        mem[12'h289] = 32'h00099062;  // 0xA24 acc0 R M
        mem[12'h28A] = 32'h000AB00E;  // 0xA28 acc3 no R/M
        mem[12'h28B] = 32'h000CD01A;  // 0xA2C acc6 no R/M
    end

    initial begin
        int rd0;
        int wr0;
        logic [35:0] pa_keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R9, R10)
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R9 reset mem_rd/mem_wr", 64'({mem_rd, mem_wr}), 64'd0);
        chk("R11 reset fault", 64'(res_fault), 64'd0);

        // table walk vectors (R1 R2 R3 R4 R5 R7 R11)
        for (int v = 0; v < NV; v++) begin
            rd0 = n_rd;
            walk(VECS[v].va, VECS[v].kind, VECS[v].sup, VECS[v].ctx, VECS[v].nf);
            chk($sformatf("R2 R4 R5 vec%0d fault", v), 64'(res_fault), 64'(VECS[v].fault));
            chk($sformatf("R3 R11 vec%0d pa", v), 64'(res_pa), 64'(VECS[v].pa));
            chk($sformatf("R3 vec%0d size", v), 64'(res_size), 64'(VECS[v].size));
            chk($sformatf("R7 vec%0d perm", v), 64'(res_perm), 64'(VECS[v].perm));
            chk($sformatf("R1 vec%0d reads", v), 64'(n_rd - rd0), 64'(VECS[v].nrd));
        end
        chk("R6 no write-back in vectors", 64'(n_wr), 64'd0);

        // R6: supervisor store to unreferenced page
        walk(32'h02045678, 2'd1, 1'b1, 8'd1, 1'b0);
        chk("R6 store wb image", 64'(mem[12'h285]), 64'h00045676);
        chk("R3 store pa", 64'(res_pa), 64'h000456678);
        chk("R7 store perm", 64'(res_perm), 64'b110);
        wr0 = n_wr;
        walk(32'h02045678, 2'd0, 1'b0, 8'd1, 1'b0);
        chk("R4 user load acc5 perm", 64'(res_perm), 64'b100);
        chk("R6 no wb when R M set", 64'(n_wr - wr0), 64'd0);
        // R6 R7: load sets referenced only, write withheld
        walk(32'h0204A000, 2'd0, 1'b1, 8'd1, 1'b0);
        chk("R6 load wb image", 64'(mem[12'h28A]), 64'h000AB02E);
        chk("R7 load perm no w", 64'(res_perm), 64'b101);
        walk(32'h0204A000, 2'd1, 1'b1, 8'd1, 1'b0);
        chk("R6 store sets modified", 64'(mem[12'h28A]), 64'h000AB06E);
        chk("R7 perm after modified", 64'(res_perm), 64'b111);
        // R6: permission fault leaves entry untouched
        wr0 = n_wr;
        walk(32'h0204B000, 2'd0, 1'b0, 8'd1, 1'b0);
        chk("R4 privilege fault", 64'(res_fault), 64'h00C);
        chk("R6 fault no wb", 64'(n_wr - wr0), 64'd0);
        chk("R6 fault entry kept", 64'(mem[12'h28B]), 64'h000CD01A);

        // R2: bus errors at each level
        err_addr = 36'h408;
        walk(32'h02012345, 2'd0, 1'b1, 8'd1, 1'b0);
        chk("R2 bus err L1", 64'(res_fault), 64'h110);
        err_addr = 36'h104;
        walk(32'h02012345, 2'd0, 1'b1, 8'd1, 1'b0);
        chk("R2 bus err ctx", 64'(res_fault), 64'h010);
        err_addr = 36'hA20;
        walk(32'h02048ABC, 2'd2, 1'b1, 8'd1, 1'b0);
        chk("R2 bus err L3", 64'(res_fault), 64'h310);
        chk("R11 bus err perm", 64'(res_perm), 64'd0);
        err_addr = '1;

        // R10: request during a walk is ignored; result held
        while (busy) @(negedge clk);
        rd0 = n_rd;
        req_va = 32'h01123456; req_kind = 2'd0; req_super = 1'b1; req_ctx = 8'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_va = 32'h03000000;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R10 ignored request pa", 64'(res_pa), 64'h002123456);
        pa_keep = res_pa;
        repeat (5) @(negedge clk);
        chk("R10 result held", 64'(res_pa), 64'(pa_keep));
        chk("R10 no second walk", 64'(n_rd - rd0), 64'd2);
        chk("R10 idle after walk", 64'(busy), 64'd0);

        // R8: untranslated modes
        cfg_translate = 1'b0;
        cfg_boot = 1'b1;
        rd0 = n_rd;
        walk(32'h12345678, 2'd2, 1'b1, 8'd1, 1'b0);
        chk("R8 boot fetch pa", 64'(res_pa), 64'h0F0045678);
        chk("R8 boot fetch perm", 64'(res_perm), 64'b101);
        chk("R8 bypass latency", 64'(lat), 64'd0);
        walk(32'h12345678, 2'd0, 1'b1, 8'd1, 1'b0);
        chk("R8 boot load pa", 64'(res_pa), 64'h012345678);
        chk("R8 boot load perm", 64'(res_perm), 64'b111);
        cfg_boot = 1'b0;
        walk(32'h12345678, 2'd2, 1'b0, 8'd1, 1'b0);
        chk("R8 plain fetch pa", 64'(res_pa), 64'h012345678);
        chk("R8 no memory reads", 64'(n_rd - rd0), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule